// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit match-and-clear timers, a lower unit and an upper unit. Each unit has a compare register and a control register with an enable bit, a cascade bit and a clock select. With the cascade bits clear, each unit counts its own prescaled ticks and pulses its own interrupt once per interval. When both cascade bits are set, the two counters form one 16-bit counter that is clocked only by the lower unit's select. Its compare value is built from both compare registers, and only the lower interrupt reports matches.

The block has no data stream, so every pin is a plain control or status pin and nothing is held off by back-pressure. Software programs the registers through a one-cycle write strobe. `tick_i` is the base count-clock enable, and a shared prescaler derives the slower count clocks from it. In fused mode the upper enable must be set before the lower one when starting, and the lower enable must be cleared before the upper one when stopping.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts, both compare registers and both control registers are zero, and `irq_lo` and `irq_hi` are low.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. Address 0 is the lower compare register, 1 is the upper compare register, 2 is the lower control register and 3 is the upper control register. In a control byte, bit 0 is the enable, bit 1 is the cascade bit and bits 3:2 are the clock select. Writes to any other address have no effect.
- R3: A 3-bit prescaler advances on every cycle with `tick_i` high. A unit whose select is k counts on a tick only when the low k bits of the prescaler are all ones just before that tick, so it counts every 2^k-th tick.
- R4: With the cascade bits clear and a unit enabled, that unit counts 0 up to its compare value N and then clears to 0, giving an interval of N+1 of its count ticks. Each unit uses its own select.
- R5: When both cascade bits are set, the 16-bit count {upper, lower} advances on the lower unit's count ticks and clears when it equals {upper compare, lower compare}. The interval is N+1 ticks, and the upper unit's select is ignored.
- R6: An interrupt is a one-cycle pulse that is high in the cycle in which its count first reads zero after a match. With N=0 it fires after every counted tick.
- R7: While the block is cascaded, `irq_hi` stays low.
- R8: While cascaded, the count advances only when both enables are set. With the lower enable set and the upper enable clear, the count holds.
- R9: Clearing the lower enable resets the count to zero. In cascade mode this clears both halves, so the next start runs a full interval. In independent mode, clearing a unit's own enable clears that unit's count.
- R10: A write to the lower compare register is ignored while the lower enable is set. A write to the upper compare register is ignored while the lower enable is set in cascade mode, and while the upper enable is set in independent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base count-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| irq_lo | output | 1 | Lower unit interrupt pulse |
| irq_hi | output | 1 | Upper unit interrupt pulse |

## Verification
Two events can fall in the same cycle: a match that clears the count and raises the interrupt, and a control write that clears the lower enable. Another pair is a compare write arriving while the timer is running. The bench uses a small compare value with `tick_i` held high, so matches come every few cycles, and it stops the timer at a cycle that lands on a match edge. A behavioural model decides each cycle which event wins, and the interrupt outputs are compared with it every clock. A later restart must then show a full N+1 interval.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int SEL_W  = 2;
  localparam int NSEL   = 1 << SEL_W;
  localparam int PSC_W  = NSEL - 1;
  localparam int CTRL_W = SEL_W + 2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             casc;
    logic             en;
  } ctrl_t;

  localparam logic [2:0] ADDR_CMP_LO  = 3'd0;
  localparam logic [2:0] ADDR_CMP_HI  = 3'd1;
  localparam logic [2:0] ADDR_CTRL_LO = 3'd2;
  localparam logic [2:0] ADDR_CTRL_HI = 3'd3;
endpackage

// File: rtl/dit_prescale.sv
module dit_prescale
  import dit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_lo_i,
  input  logic [SEL_W-1:0] sel_hi_i,
  output logic             strobe_lo_o,
  output logic             strobe_hi_o
);
  logic [PSC_W-1:0] psc_q;
  logic [NSEL-1:0]  strb;

  always_ff @(posedge clk) begin
    if (!rst_n)      psc_q <= '0;
    else if (tick_i) psc_q <= psc_q + 1'b1;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_div
    localparam logic [PSC_W-1:0] MASK = PSC_W'((1 << k) - 1);
    assign strb[k] = tick_i & (&(psc_q | ~MASK));
  end

  assign strobe_lo_o = strb[sel_lo_i];
  assign strobe_hi_o = strb[sel_hi_i];
endmodule

// File: rtl/dit_count.sv
module dit_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam int UNITS = 2;

  logic [CW-1:0] cmp_q [UNITS];
  ctrl_t         ctrl_q [UNITS];
  logic [CW-1:0] cnt [UNITS];
  logic [UNITS-1:0] clr, inc, fire, strobe;
  logic casc, en_lo, en_hi, run16, match16;

  assign casc  = ctrl_q[0].casc & ctrl_q[1].casc;
  assign en_lo = ctrl_q[0].en;
  assign en_hi = ctrl_q[1].en;

  // Register write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < UNITS; u++) begin
        cmp_q[u]  <= '0;
        ctrl_q[u] <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CMP_LO:  if (!en_lo) cmp_q[0] <= wr_data;
        ADDR_CMP_HI:  if (!(casc ? en_lo : en_hi)) cmp_q[1] <= wr_data;
        ADDR_CTRL_LO: ctrl_q[0] <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_CTRL_HI: ctrl_q[1] <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  dit_prescale u_psc (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .sel_lo_i    (ctrl_q[0].sel),
    .sel_hi_i    (ctrl_q[1].sel),
    .strobe_lo_o (strobe[0]),
    .strobe_hi_o (strobe[1])
  );

  assign run16   = en_lo & en_hi & strobe[0];
  assign match16 = ({cnt[1], cnt[0]} == {cmp_q[1], cmp_q[0]});

  always_comb begin
    if (casc) begin
      fire[0] = run16 & match16;
      fire[1] = 1'b0;
      clr[0]  = ~en_lo | fire[0];
      clr[1]  = clr[0];
      inc[0]  = run16 & ~match16;
      inc[1]  = inc[0] & (&cnt[0]);
    end else begin
      for (int u = 0; u < UNITS; u++) begin
        fire[u] = ctrl_q[u].en & strobe[u] & (cnt[u] == cmp_q[u]);
        clr[u]  = ~ctrl_q[u].en | fire[u];
        inc[u]  = ctrl_q[u].en & strobe[u];
      end
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    dit_count #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr[u]),
      .inc_i (inc[u]),
      .cnt_o (cnt[u])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= fire[0];
      irq_hi <= fire[1];
    end
  end

  // Assertions
  assert_hi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    casc |=> !irq_hi);
  assert_irq_lo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (cnt[0] == '0));
  assert_irq_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (cnt[1] == '0));
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lo |=> (cnt[0] == '0));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && en_lo && !en_hi) |=> $stable({cnt[1], cnt[0]}));
  assert_cmp_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CMP_LO && en_lo) |=> $stable(cmp_q[0]));
endmodule

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq_lo, irq_hi;
  int checks = 0, failures = 0;
  bit done = 1'b0, rnd_tick = 1'b0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  dual_interval_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_lo(irq_lo), .irq_hi(irq_hi));

  // Behavioural reference model
  int m_cmp[2], m_en[2], m_cs[2], m_sel[2], m_cnt[2], m_psc;
  bit m_il, m_ih;

  function automatic bit strb(int psc, int s, bit t);
    return t && ((psc % (1 << s)) == ((1 << s) - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp = '{0, 0}; m_en = '{0, 0}; m_cs = '{0, 0}; m_sel = '{0, 0};
      m_cnt = '{0, 0}; m_psc = 0; m_il = 0; m_ih = 0;
    end else begin
      automatic bit cas = m_cs[0] && m_cs[1];
      automatic bit s0 = strb(m_psc, m_sel[0], tick_i);
      automatic bit s1 = strb(m_psc, m_sel[1], tick_i);
      automatic int n0 = m_cnt[0], n1 = m_cnt[1];
      automatic bit il = 0, ih = 0;
      if (cas) begin
        if (!m_en[0]) begin n0 = 0; n1 = 0; end
        else if (m_en[1] && s0) begin
          automatic int v = m_cnt[1] * 256 + m_cnt[0];
          if (v == m_cmp[1] * 256 + m_cmp[0]) begin v = 0; il = 1; end
          else v = v + 1;
          n0 = v % 256; n1 = v / 256;
        end
      end else begin
        if (!m_en[0]) n0 = 0;
        else if (s0) begin if (m_cnt[0] == m_cmp[0]) begin n0 = 0; il = 1; end else n0 = n0 + 1; end
        if (!m_en[1]) n1 = 0;
        else if (s1) begin if (m_cnt[1] == m_cmp[1]) begin n1 = 0; ih = 1; end else n1 = n1 + 1; end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (!m_en[0]) m_cmp[0] = wr_data;
          3'd1: if (!(cas ? m_en[0] : m_en[1])) m_cmp[1] = wr_data;
          3'd2, 3'd3: begin
            automatic int u = wr_addr - 2;
            m_en[u] = wr_data[0]; m_cs[u] = wr_data[1]; m_sel[u] = wr_data[3:2];
          end
          default: ;
        endcase
      end
      if (tick_i) m_psc = (m_psc + 1) % 8;
      m_cnt[0] = n0; m_cnt[1] = n1; m_il = il; m_ih = ih;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_lo !== m_il || irq_hi !== m_ih) begin
        failures++;
        $display("FAIL %s: irq_lo/irq_hi actual=%b%b expected=%b%b", phase, irq_lo, irq_hi, m_il, m_ih);
      end
    end
  end

  always @(negedge clk) tick_i <= rnd_tick ? 1'($urandom % 2) : 1'b1;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1 reset idle"; idle(5);
    // R2 R3 R4: independent units with different selects
    phase = "R2 R3 R4 independent";
    wr(3'd0, 8'd3); wr(3'd1, 8'd5); wr(3'd5, 8'hFF);
    wr(3'd2, 8'b0000_0001); wr(3'd3, 8'b0000_0101);
    idle(80);
    // R10: compare writes while running are ignored
    phase = "R10 locked compare indep";
    wr(3'd0, 8'd9); wr(3'd1, 8'd1); idle(60);
    // R9: stop independent units
    phase = "R9 stop indep";
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); idle(10);
    // R5 R7: cascade, upper select ignored, random ticks
    phase = "R5 R7 cascade";
    rnd_tick = 1'b1;
    wr(3'd0, 8'h10); wr(3'd1, 8'h01);
    wr(3'd3, 8'b0000_1111); wr(3'd2, 8'b0000_0010); wr(3'd2, 8'b0000_0011);
    idle(1300);
    phase = "R10 locked compare cascade";
    wr(3'd0, 8'h02); wr(3'd1, 8'h00); idle(700);
    // R8: upper enable dropped, count holds
    phase = "R8 hold";
    wr(3'd3, 8'b0000_0010); idle(40);
    wr(3'd3, 8'b0000_0011); idle(300);
    // R6: N=0 in cascade
    phase = "R6 zero interval";
    rnd_tick = 1'b0;
    wr(3'd2, 8'b0000_0010); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd2, 8'b0000_0011); idle(20);
    // R9: stop on match cycles and restart
    phase = "R9 stop on match";
    wr(3'd2, 8'b0000_0010); wr(3'd0, 8'h02);
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, 8'b0000_0011); idle(i);
      wr(3'd2, 8'b0000_0010); idle(3);
    end
    wr(3'd2, 8'b0000_0011); idle(30);
    // R6 R4: N=0 independent, select 0
    phase = "R6 R4 zero indep";
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'h01);
    wr(3'd2, 8'b0000_0001); wr(3'd3, 8'b0000_1001); idle(60);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule